// File: doc/BRIEF.md
# Serial Command/Data Mode Dispatcher

This block sits between a byte-wide UART receiver and a single-wire bus engine. Host bytes arrive on one stream that carries both control and payload. The block sorts each byte into one of three outcomes: it is a payload byte that becomes one bus transaction of eight time slots, it is a command that becomes a decoded request to the engine, or it changes the operating mode. For every payload byte it returns exactly one result byte to the UART transmitter, once the engine reports that the bus activity has finished.

The block is a state machine with six states. `ST_CALIB` is command mode with the calibration byte still pending. Any byte accepted there is consumed, and the machine moves to `ST_CMD`. In `ST_CMD` (command mode), code E1h moves the machine to `ST_DATA`. A recognised command issues a request and moves to `ST_BUSY`. An unrecognised byte leaves the machine in `ST_CMD`. In `ST_DATA` (data mode), E3h moves the machine to `ST_ESC`. Any other byte issues a data request and moves to `ST_BUSY`. In `ST_ESC`, a second E3h issues a data request carrying E3h. Any other byte is decoded as a command, and the machine leaves for `ST_BUSY` if that command is recognised or for `ST_CMD` if it is not. `ST_BUSY` waits for the engine's done strobe. It then goes to `ST_REPLY` after a data request, or to `ST_CMD` after a command. `ST_REPLY` offers the result byte and returns to `ST_DATA` once the transmitter takes it. Asynchronous reset and the synchronous master-reset input both force `ST_CALIB`.

Top module: `serial_mode_dispatcher`

## Requirements
- R1: After `rst_n` deasserts, and in the cycle after `mreset` is sampled high, the state is `ST_CALIB`: `rx_ready`=1, `req_valid`=0, `tx_valid`=0. This holds even when a transaction is in progress.
- R2: The first byte accepted in `ST_CALIB` causes no request and no reply, and `rx_ready` stays 1. The same byte value is executed normally when it arrives again.
- R3: In command mode, byte E1h selects data mode and causes no request.
- R4: In data mode, a byte other than E3h raises `req_valid` in the cycle after it is accepted, with `req_kind`=0 (data) and `req_byte` equal to the byte.
- R5: After a data request, the result presented with `eng_done` appears on `tx_data`, with `tx_valid`=1, in the cycle after the done strobe. Both hold until `tx_ready` is sampled high. Then `tx_valid` drops and `rx_ready` returns to 1.
- R6: In data mode, E3h followed by E3h produces exactly one data request, with `req_byte`=E3h. The first E3h produces no request.
- R7: In data mode, E3h followed by any other byte returns the machine to command mode, and that second byte is decoded as a command.
- R8: A byte 0ZZZVVV1 decodes to `req_kind`=1 (configuration), with `req_arg_a`=bits 6:4 and `req_arg_b`=bits 3:1.
- R9: A byte 100VSSP1 decodes to `req_kind`=2 (single bit), with `req_arg_a`={2'b0,V}, `req_arg_b`={2'b0,P} and `req_speed`=SS (bits 3:2). A byte 101HSS01 decodes to `req_kind`=3 (search on/off) and a byte 110XSS01 decodes to `req_kind`=4 (bus reset). For both, `req_arg_a`={2'b0,bit 4}, `req_arg_b`=0 and `req_speed`=bits 3:2.
- R10: A byte 111T11Q1 decodes to `req_kind`=5 (pulse), with `req_arg_a`={2'b0,T}, `req_arg_b`={2'b0,Q} and `req_speed`=0.
- R11: In command mode, a byte with bit 0 clear, or one that matches none of the command forms, raises no request and no reply, and `rx_ready` stays 1.
- R12: Between a request and its `eng_done`, `rx_ready` is 0. A command request produces no reply byte.
- R13: `req_valid` is high for exactly one cycle per request. In every request, `req_byte` carries the accepted byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mreset | input | 1 | Synchronous master reset, active high |
| rx_valid | input | 1 | Received byte available |
| rx_data | input | 8 | Received byte |
| rx_ready | output | 1 | Block accepts a byte this cycle |
| req_valid | output | 1 | One-cycle request to the bus engine |
| req_kind | output | 3 | 0 data, 1 config, 2 bit, 3 search, 4 reset, 5 pulse |
| req_byte | output | 8 | Data byte or raw command byte |
| req_arg_a | output | 3 | First decoded field |
| req_arg_b | output | 3 | Second decoded field |
| req_speed | output | 2 | Bus speed selection |
| eng_done | input | 1 | Engine finished the current request |
| eng_result | input | 8 | Byte read back from the bus |
| tx_valid | output | 1 | Result byte offered to the transmitter |
| tx_data | output | 8 | Result byte |
| tx_ready | input | 1 | Transmitter takes the result byte |

## Verification
A byte is accepted on the clock edge where `rx_valid` and `rx_ready` are both high. A resulting request is visible one cycle later. A reply is visible one cycle after the edge that samples `eng_done`. `tx_valid` clears, and `rx_ready` returns, one cycle after the edge that samples `tx_ready`. The bench drives every input on the falling edge. It checks each of these results at the falling edge that follows the rising edge named here, and never earlier. It also checks, one cycle later, that `req_valid` has fallen and `rx_ready` is still low while the engine is busy.

// File: rtl/smd_pkg.sv
package smd_pkg;

    typedef enum logic [2:0] {
        K_DATA   = 3'd0,
        K_CONFIG = 3'd1,
        K_BIT    = 3'd2,
        K_SEARCH = 3'd3,
        K_RESET  = 3'd4,
        K_PULSE  = 3'd5
    } req_kind_e;

    typedef struct packed {
        logic      hit;
        req_kind_e kind;
        logic [2:0] arg_a;
        logic [2:0] arg_b;
        logic [1:0] speed;
    } cmd_dec_t;

    typedef enum logic [2:0] {
        ST_CALIB,
        ST_CMD,
        ST_DATA,
        ST_ESC,
        ST_BUSY,
        ST_REPLY
    } mode_state_e;

endpackage

// File: rtl/smd_cmd_decoder.sv
module smd_cmd_decoder
    import smd_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] code,
    output cmd_dec_t     dec
);

    localparam int TOP = W - 1;

    always_comb begin
        dec = '{hit: 1'b0, kind: K_DATA, arg_a: 3'd0, arg_b: 3'd0, speed: 2'd0};
        if (code[0]) begin
            if (!code[TOP]) begin
                // configuration write: parameter and value fields
                dec.hit   = 1'b1;
                dec.kind  = K_CONFIG;
                dec.arg_a = code[6:4];
                dec.arg_b = code[3:1];
            end else begin
                unique case (code[6:5])
                    2'b00: begin
                        dec.hit   = 1'b1;
                        dec.kind  = K_BIT;
                        dec.arg_a = {2'b00, code[4]};
                        dec.arg_b = {2'b00, code[1]};
                        dec.speed = code[3:2];
                    end
                    2'b01: if (!code[1]) begin
                        dec.hit   = 1'b1;
                        dec.kind  = K_SEARCH;
                        dec.arg_a = {2'b00, code[4]};
                        dec.speed = code[3:2];
                    end
                    2'b10: if (!code[1]) begin
                        dec.hit   = 1'b1;
                        dec.kind  = K_RESET;
                        dec.arg_a = {2'b00, code[4]};
                        dec.speed = code[3:2];
                    end
                    2'b11: if (code[3:2] == 2'b11) begin
                        dec.hit   = 1'b1;
                        dec.kind  = K_PULSE;
                        dec.arg_a = {2'b00, code[4]};
                        dec.arg_b = {2'b00, code[1]};
                    end
                    default: ;
                endcase
            end
        end
    end

endmodule

// File: rtl/serial_mode_dispatcher.sv
module serial_mode_dispatcher
    import smd_pkg::*;
#(
    parameter int         BYTE_W    = 8,
    parameter logic [7:0] DATA_CODE = 8'hE1,
    parameter logic [7:0] ESC_CODE  = 8'hE3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mreset,
    input  logic              rx_valid,
    input  logic [BYTE_W-1:0] rx_data,
    output logic              rx_ready,
    output logic              req_valid,
    output logic [2:0]        req_kind,
    output logic [BYTE_W-1:0] req_byte,
    output logic [2:0]        req_arg_a,
    output logic [2:0]        req_arg_b,
    output logic [1:0]        req_speed,
    input  logic              eng_done,
    input  logic [BYTE_W-1:0] eng_result,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_data,
    input  logic              tx_ready
);

    mode_state_e state, state_nxt;
    cmd_dec_t    dec;
    logic        accept;
    logic        issue;
    logic        issue_data;
    logic        busy_is_data;

    smd_cmd_decoder #(.W(BYTE_W)) u_dec (
        .code (rx_data),
        .dec  (dec)
    );

    assign rx_ready = (state == ST_CALIB) || (state == ST_CMD) ||
                      (state == ST_DATA)  || (state == ST_ESC);
    assign accept   = rx_valid && rx_ready;

    // next state and request issue
    always_comb begin
        state_nxt  = state;
        issue      = 1'b0;
        issue_data = 1'b0;
        unique case (state)
            ST_CALIB: if (accept) state_nxt = ST_CMD;
            ST_CMD: if (accept) begin
                if (rx_data == DATA_CODE) begin
                    state_nxt = ST_DATA;
                end else if (dec.hit) begin
                    issue     = 1'b1;
                    state_nxt = ST_BUSY;
                end
            end
            ST_DATA: if (accept) begin
                if (rx_data == ESC_CODE) begin
                    state_nxt = ST_ESC;
                end else begin
                    issue      = 1'b1;
                    issue_data = 1'b1;
                    state_nxt  = ST_BUSY;
                end
            end
            ST_ESC: if (accept) begin
                if (rx_data == ESC_CODE) begin
                    issue      = 1'b1;
                    issue_data = 1'b1;
                    state_nxt  = ST_BUSY;
                end else if (dec.hit) begin
                    issue     = 1'b1;
                    state_nxt = ST_BUSY;
                end else begin
                    state_nxt = ST_CMD;
                end
            end
            ST_BUSY: if (eng_done) state_nxt = busy_is_data ? ST_REPLY : ST_CMD;
            ST_REPLY: if (tx_ready) state_nxt = ST_DATA;
            default: state_nxt = ST_CALIB;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      state <= ST_CALIB;
        else if (mreset) state <= ST_CALIB;
        else             state <= state_nxt;
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_valid    <= 1'b0;
            req_kind     <= 3'd0;
            req_byte     <= '0;
            req_arg_a    <= 3'd0;
            req_arg_b    <= 3'd0;
            req_speed    <= 2'd0;
            busy_is_data <= 1'b0;
            tx_valid     <= 1'b0;
            tx_data      <= '0;
        end else if (mreset) begin
            req_valid    <= 1'b0;
            busy_is_data <= 1'b0;
            tx_valid     <= 1'b0;
        end else begin
            req_valid <= issue;
            if (issue) begin
                req_byte     <= rx_data;
                busy_is_data <= issue_data;
                if (issue_data) begin
                    req_kind  <= K_DATA;
                    req_arg_a <= 3'd0;
                    req_arg_b <= 3'd0;
                    req_speed <= 2'd0;
                end else begin
                    req_kind  <= dec.kind;
                    req_arg_a <= dec.arg_a;
                    req_arg_b <= dec.arg_b;
                    req_speed <= dec.speed;
                end
            end
            if (state == ST_BUSY && eng_done && busy_is_data) begin
                tx_valid <= 1'b1;
                tx_data  <= eng_result;
            end else if (tx_valid && tx_ready) begin
                tx_valid <= 1'b0;
            end
        end
    end

    // checks next to the logic they guard
    p_req_single_r13: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> !req_valid);

    p_req_after_accept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $past(rx_valid && rx_ready));

    p_busy_blocks_rx_r12: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> !rx_ready);

    p_reply_after_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(eng_done));

    p_reply_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_ready && !mreset) |=> (tx_valid && $stable(tx_data)));

    p_mreset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        mreset |=> (rx_ready && !req_valid && !tx_valid));

endmodule

// File: tb/serial_mode_dispatcher_tb.sv
module serial_mode_dispatcher_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mreset = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = 8'h00;
    logic       rx_ready;
    logic       req_valid;
    logic [2:0] req_kind;
    logic [7:0] req_byte;
    logic [2:0] req_arg_a;
    logic [2:0] req_arg_b;
    logic [1:0] req_speed;
    logic       eng_done = 1'b0;
    logic [7:0] eng_result = 8'h00;
    logic       tx_valid;
    logic [7:0] tx_data;
    logic       tx_ready = 1'b0;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  finished = 1'b0;

    always #5 clk = ~clk;

    serial_mode_dispatcher u_dut (
        .clk(clk), .rst_n(rst_n), .mreset(mreset),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .req_valid(req_valid), .req_kind(req_kind), .req_byte(req_byte),
        .req_arg_a(req_arg_a), .req_arg_b(req_arg_b), .req_speed(req_speed),
        .eng_done(eng_done), .eng_result(eng_result),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
    );

    // byte, expect request, kind, arg_a, arg_b, speed
    localparam int NV = 9;
    localparam logic [19:0] VEC [NV] = '{
        {8'h5B, 1'b1, 3'd1, 3'd5, 3'd5, 2'd0},  // R8 config
        {8'h97, 1'b1, 3'd2, 3'd1, 3'd1, 2'd1},  // R9 single bit
        {8'hB9, 1'b1, 3'd3, 3'd1, 3'd0, 2'd2},  // R9 search
        {8'hCD, 1'b1, 3'd4, 3'd0, 3'd0, 2'd3},  // R9 bus reset
        {8'hFD, 1'b1, 3'd5, 3'd1, 3'd0, 2'd0},  // R10 pulse
        {8'hEF, 1'b1, 3'd5, 3'd0, 3'd1, 2'd0},  // R10 pulse
        {8'h5A, 1'b0, 3'd0, 3'd0, 3'd0, 2'd0},  // R11 low bit clear
        {8'hA3, 1'b0, 3'd0, 3'd0, 3'd0, 2'd0},  // R11 no form
        {8'hE3, 1'b0, 3'd0, 3'd0, 3'd0, 2'd0}   // R11 no form
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic send_byte(input logic [7:0] b);
        rx_valid = 1'b1;
        rx_data  = b;
        @(posedge clk);
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic finish_eng(input logic [7:0] res);
        eng_done   = 1'b1;
        eng_result = res;
        @(posedge clk);
        @(negedge clk);
        eng_done = 1'b0;
    endtask

    task automatic take_tx();
        tx_ready = 1'b1;
        @(posedge clk);
        @(negedge clk);
        tx_ready = 1'b0;
    endtask

    task automatic chk_req(input string tag, input logic [2:0] k, input logic [7:0] b,
                           input logic [2:0] a, input logic [2:0] bb, input logic [1:0] sp);
        chk({tag, " req_valid"}, req_valid, 1);
        chk({tag, " req_kind"}, req_kind, k);
        chk({tag, " req_byte"}, req_byte, b);
        chk({tag, " req_arg_a"}, req_arg_a, a);
        chk({tag, " req_arg_b"}, req_arg_b, bb);
        chk({tag, " req_speed"}, req_speed, sp);
    endtask

    task automatic chk_idle(input string tag);
        chk({tag, " req_valid"}, req_valid, 0);
        chk({tag, " rx_ready"}, rx_ready, 1);
        chk({tag, " tx_valid"}, tx_valid, 0);
    endtask

    // command request already visible: check pulse, busy, then done with no reply
    task automatic close_cmd(input string tag);
        @(negedge clk);
        chk({tag, " R13 pulse"}, req_valid, 0);
        chk({tag, " R12 busy"}, rx_ready, 0);
        finish_eng(8'h77);
        chk({tag, " R12 no reply"}, tx_valid, 0);
        chk({tag, " R12 ready"}, rx_ready, 1);
    endtask

    task automatic close_data(input string tag, input logic [7:0] res);
        @(negedge clk);
        chk({tag, " R13 pulse"}, req_valid, 0);
        chk({tag, " R12 busy"}, rx_ready, 0);
        finish_eng(res);
        chk({tag, " R5 tx_valid"}, tx_valid, 1);
        chk({tag, " R5 tx_data"}, tx_data, res);
        @(negedge clk);
        chk({tag, " R5 hold valid"}, tx_valid, 1);
        chk({tag, " R5 hold data"}, tx_data, res);
        take_tx();
        chk({tag, " R5 tx drop"}, tx_valid, 0);
        chk({tag, " R5 rx_ready"}, rx_ready, 1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk_idle("R1 reset");

        // R2 calibration byte consumed, then same value executes
        send_byte(8'hC1);
        chk_idle("R2 calib");
        send_byte(8'hC1);
        chk_req("R2 second", 3'd4, 8'hC1, 3'd0, 3'd0, 2'd0);
        close_cmd("R2 second");

        // table of command-mode vectors
        for (int i = 0; i < NV; i++) begin
            logic [19:0] v;
            v = VEC[i];
            send_byte(v[19:12]);
            if (v[11]) begin
                chk_req("R8/R9/R10 vec", v[10:8], v[19:12], v[7:5], v[4:2], v[1:0]);
                close_cmd("vec");
            end else begin
                chk_idle("R11 ignored");
            end
        end

        // R3 enter data mode, R4 data request
        send_byte(8'hE1);
        chk_idle("R3 switch");
        send_byte(8'h3C);
        chk_req("R4 data", 3'd0, 8'h3C, 3'd0, 3'd0, 2'd0);
        close_data("R4", 8'hA5);

        // R6 doubled escape
        send_byte(8'hE3);
        chk_idle("R6 first esc");
        send_byte(8'hE3);
        chk_req("R6 esc data", 3'd0, 8'hE3, 3'd0, 3'd0, 2'd0);
        close_data("R6", 8'h11);

        // R7 escape then command
        send_byte(8'hE3);
        chk_idle("R7 esc");
        send_byte(8'hCD);
        chk_req("R7 cmd", 3'd4, 8'hCD, 3'd0, 3'd0, 2'd3);
        close_cmd("R7");
        send_byte(8'h55);
        chk_req("R7 cmd mode", 3'd1, 8'h55, 3'd5, 3'd2, 2'd0);
        close_cmd("R7 cfg");

        // R1 master reset during a data transaction
        send_byte(8'hE1);
        send_byte(8'h20);
        chk_req("R4 before mreset", 3'd0, 8'h20, 3'd0, 3'd0, 2'd0);
        mreset = 1'b1;
        @(posedge clk);
        @(negedge clk);
        mreset = 1'b0;
        chk_idle("R1 mreset");
        finish_eng(8'h99);
        chk_idle("R1 stray done");
        send_byte(8'h97);
        chk_idle("R2 calib after mreset");
        send_byte(8'h97);
        chk_req("R2 exec after mreset", 3'd2, 8'h97, 3'd1, 3'd1, 2'd1);
        close_cmd("R2 final");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule